// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Interrupt and Reset Stages

This block guards a processor against a hang. A single down-counter is reloaded each time software services the watchdog (a "pet"). If no pet arrives within an early, programmable number of ticks, the block raises an interrupt (the bark). Software can then recover or save state. If the silence lasts until a second, later limit, the block raises a system reset request (the bite). A pet that lands between the two stages withdraws the interrupt and restarts both limits, so the reset never fires.

Time is measured in ticks from a built-in prescaler. One tick lasts `div + 1` clock cycles. Software drives the block through a small write-only port with four registers, selected by `wr_addr`:

- Address 0 is control. Bit 0 is the enable.
- Address 1 holds both limits. Bits [15:0] are the bark limit and bits [31:16] are the bite limit.
- Address 2 sets the prescaler divisor in bits [7:0].
- Address 3 is the pet strobe. Any write to it counts as a pet; the data is ignored.

The interrupt has its own acknowledge input. The reset request is sticky until the block's own reset.

Top module: `wdt_barkbite`

## Requirements
- R1: After `rst_n` is released, `bark_irq` and `bite_rst` are low, the watchdog is disabled, the limits are bark 11 and bite 12 ticks, and the divisor is 0.
- R2: Each tick lasts `div + 1` clock cycles. The divisor is written at address 2, bits [7:0]. All limits count in ticks.
- R3: A restart edge is the clock edge that captures a pet, an enabling write, or an accepted limit write. With no later restart, `bark_irq` reads high `bark * (div + 1)` cycles after the last restart edge.
- R4: With no later restart, `bite_rst` reads high `bite * (div + 1)` cycles after the last restart edge. It then stays high, through pets and acknowledges, until `rst_n` is asserted.
- R5: `bark_irq` stays high until `bark_ack` is pulsed, which clears it on the next edge. An acknowledge does not restart counting.
- R6: A pet (write to address 3) after the bark and before the bite clears `bark_irq` on its edge and restarts both limits, so no bite occurs.
- R7: When a pet is captured on the same edge at which an expiry would be registered, the pet wins and nothing expires.
- R8: A limit write (address 1, bark in bits [15:0], bite in bits [31:16]) is rejected if bark is 0 or bite is not greater than bark. A rejected write leaves the previous limits in place and does not restart counting.
- R9: While the enable (address 0, bit 0) is clear, the counter is held at its reload value and neither output can rise. Setting the enable starts a fresh count.
- R10: An accepted limit write restarts counting, and the new limits apply from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset of the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 limits, 2 divisor, 3 pet |
| wr_data | input | 32 | Write data |
| bark_ack | input | 1 | Acknowledge pulse for the bark interrupt |
| bark_irq | output | 1 | Bark interrupt request, level |
| bite_rst | output | 1 | Sticky system reset request |

## Verification
A counter that is loaded wrongly or decremented off-tick shows up at the ports as early or late edges. The bark or bite edge lands at a cycle other than `limit * (div + 1)` after the restart, and the very first expiry of every run exposes it. A bad threshold compare shows up the same way: the bark fires at the bite time, or never fires at all. A lost sticky bit or a mishandled pet priority becomes visible within one cycle of the pet or acknowledge that follows the expiry. A limit check that accepts bad values shifts the next bark by the difference between the old and new limits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 2'd0,
    REG_LIMITS   = 2'd1,
    REG_PRESCALE = 2'd2,
    REG_PET      = 2'd3
  } wdt_reg_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  function automatic logic at_terminal(input logic [PRE_W-1:0] cur,
                                       input logic [PRE_W-1:0] lim);
    return cur == lim;
  endfunction

  assign tick = run && !clear && at_terminal(pre_q, div);

  always_ff @(posedge clk) begin
    if (!rst_n)               pre_q <= '0;
    else if (!run || clear)   pre_q <= '0;
    else if (tick)            pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  // R2: phase never passes the divisor, and a tick wraps the phase
  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= div);
  assert_tick_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pre_q == '0);
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int DEF_BARK = 11,
  parameter int DEF_BITE = 12,
  parameter int DEF_DIV  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [2*CNT_W-1:0] wr_data,
  output logic               en,
  output logic [CNT_W-1:0]   bark_lim,
  output logic [CNT_W-1:0]   bite_lim,
  output logic [PRE_W-1:0]   div,
  output logic               pet,
  output logic               lim_load,
  output logic               pre_clear,
  output logic               ctrl_on,
  output logic [CNT_W-1:0]   reload_val
);
  logic             en_q;
  logic [CNT_W-1:0] bark_q, bite_q;
  logic [PRE_W-1:0] div_q;
  logic             wr_ctrl, wr_lim, wr_pre;
  logic [CNT_W-1:0] new_bark, new_bite;

  function automatic logic limits_ok(input logic [CNT_W-1:0] b,
                                     input logic [CNT_W-1:0] t);
    return (b != '0) && (t > b);
  endfunction

  assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
  assign wr_lim   = wr_en && (wr_addr == REG_LIMITS);
  assign wr_pre   = wr_en && (wr_addr == REG_PRESCALE);
  assign pet      = wr_en && (wr_addr == REG_PET);
  assign new_bark = wr_data[CNT_W-1:0];
  assign new_bite = wr_data[2*CNT_W-1:CNT_W];
  assign lim_load = wr_lim && limits_ok(new_bark, new_bite);
  assign pre_clear = wr_pre;
  assign ctrl_on  = wr_ctrl && wr_data[0] && !en_q;
  assign reload_val = lim_load ? new_bite : bite_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bark_q <= CNT_W'(DEF_BARK);
      bite_q <= CNT_W'(DEF_BITE);
      div_q  <= PRE_W'(DEF_DIV);
    end else begin
      if (wr_ctrl)  en_q <= wr_data[0];
      if (lim_load) begin
        bark_q <= new_bark;
        bite_q <= new_bite;
      end
      if (wr_pre)   div_q <= wr_data[PRE_W-1:0];
    end
  end

  assign en       = en_q;
  assign bark_lim = bark_q;
  assign bite_lim = bite_q;
  assign div      = div_q;

  // R8: held limits are always ordered, and a refused write changes nothing
  assert_limit_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bark_q != '0) && (bite_q > bark_q));
  assert_reject_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lim && !lim_load) |=> ($stable(bark_q) && $stable(bite_q)));
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W    = 16,
  parameter int DEF_BITE = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] bark_lim,
  input  logic [CNT_W-1:0] bite_lim,
  input  logic             bark_ack,
  output logic             bark_irq,
  output logic             bite_rst
);
  logic [CNT_W-1:0] cnt_q, cnt_dec;
  logic             counting, bark_hit, bite_hit;
  logic             bark_q, bite_q;

  // remaining count at which the early stage fires
  function automatic logic [CNT_W-1:0] bark_mark(input logic [CNT_W-1:0] b,
                                                 input logic [CNT_W-1:0] t);
    return t - b;
  endfunction

  assign counting = en && !restart && tick && (cnt_q != '0);
  assign cnt_dec  = cnt_q - 1'b1;
  assign bark_hit = counting && (cnt_dec == bark_mark(bark_lim, bite_lim));
  assign bite_hit = counting && (cnt_dec == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= CNT_W'(DEF_BITE);
    else if (!en || restart)   cnt_q <= reload_val;
    else if (counting)         cnt_q <= cnt_dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                bark_q <= 1'b0;
    else if (!en || restart)   bark_q <= 1'b0;
    else if (bark_hit)         bark_q <= 1'b1;
    else if (bark_ack)         bark_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                bite_q <= 1'b0;
    else if (bite_hit)         bite_q <= 1'b1;
  end

  assign bark_irq = bark_q;
  assign bite_rst = bite_q;

  assert_bite_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bite_q |=> bite_q);
  assert_bite_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bite_q) |-> (cnt_q == '0));
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bark_q && bark_ack && !bark_hit) |=> !bark_q);
  assert_pet_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !bark_q);
  assert_pet_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !$rose(bite_q));
  assert_quiet_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bark_q && !$rose(bite_q)));
  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == bite_lim));
endmodule

// File: rtl/wdt_barkbite.sv
module wdt_barkbite
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int DEF_BARK = 11,
  parameter int DEF_BITE = 12,
  parameter int DEF_DIV  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [2*CNT_W-1:0] wr_data,
  input  logic               bark_ack,
  output logic               bark_irq,
  output logic               bite_rst
);
  logic             en, pet, lim_load, pre_clear, ctrl_on, restart, tick;
  logic [CNT_W-1:0] bark_lim, bite_lim, reload_val;
  logic [PRE_W-1:0] div;

  wdt_cfg #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .DEF_BARK(DEF_BARK),
    .DEF_BITE(DEF_BITE), .DEF_DIV(DEF_DIV)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en(en), .bark_lim(bark_lim), .bite_lim(bite_lim),
    .div(div), .pet(pet), .lim_load(lim_load), .pre_clear(pre_clear),
    .ctrl_on(ctrl_on), .reload_val(reload_val)
  );

  // every event that starts a fresh measurement window
  assign restart = pet || lim_load || ctrl_on;

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en), .clear(restart || pre_clear),
    .div(div), .tick(tick)
  );

  wdt_core #(.CNT_W(CNT_W), .DEF_BITE(DEF_BITE)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .restart(restart),
    .reload_val(reload_val), .bark_lim(bark_lim), .bite_lim(bite_lim),
    .bark_ack(bark_ack), .bark_irq(bark_irq), .bite_rst(bite_rst)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!bark_irq && !bite_rst));
endmodule

// File: tb/sim_wdt_barkbite.sv
module sim_wdt_barkbite;
  localparam int CLK_NS = 10;
  localparam int NVEC = 5;
  // divisor, bark limit, bite limit
  localparam int VEC [NVEC][3] = '{
    '{0, 11, 12}, '{0, 6, 22}, '{1, 3, 5}, '{3, 2, 7}, '{2, 13, 20}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        bark_ack = 1'b0;
  logic        bark_irq, bite_rst;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  wdt_barkbite u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bark_ack(bark_ack), .bark_irq(bark_irq),
    .bite_rst(bite_rst)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int window(input int lim, input int dv);
    int acc = 0;
    for (int k = 0; k <= dv; k++) acc += lim;
    return acc;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); bark_ack = 1'b1;
    @(posedge clk); #1; bark_ack = 1'b0;
  endtask

  task automatic measure(input int maxc, output int nb, output int nt);
    nb = -1; nt = -1;
    for (int n = 1; n <= maxc; n++) begin
      @(posedge clk); #1;
      if (nb < 0 && bark_irq) nb = n;
      if (bite_rst) begin nt = n; break; end
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nb, nt, seen;
    do_reset();
    #1;
    check("R1 bark after reset", int'(bark_irq), 0);
    check("R1 bite after reset", int'(bite_rst), 0);
    repeat (40) @(posedge clk);
    #1;
    check("R1 disabled by default", int'(bark_irq | bite_rst), 0);
    wr(2'd0, 32'd1);
    measure(100, nb, nt);
    check("R1 default bark", nb, 11);
    check("R1 default bite", nt, 12);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      wr(2'd2, 32'(VEC[v][0]));
      wr(2'd1, {16'(VEC[v][2]), 16'(VEC[v][1])});
      wr(2'd0, 32'd1);
      measure(500, nb, nt);
      check("R2 R3 bark timing", nb, window(VEC[v][1], VEC[v][0]));
      check("R2 R4 bite timing", nt, window(VEC[v][2], VEC[v][0]));
    end

    // R5: acknowledge clears, no restart
    do_reset();
    wr(2'd1, {16'd8, 16'd3});
    wr(2'd0, 32'd1);
    repeat (3) @(posedge clk);
    #1;
    check("R3 bark high", int'(bark_irq), 1);
    ack();
    check("R5 ack clears bark", int'(bark_irq), 0);
    measure(50, nb, nt);
    check("R5 bark stays low after ack", nb, -1);
    check("R5 ack does not restart", nt, 4);

    // R6: pet between stages
    do_reset();
    wr(2'd1, {16'd8, 16'd3});
    wr(2'd0, 32'd1);
    repeat (4) @(posedge clk);
    #1;
    check("R5 bark held without ack", int'(bark_irq), 1);
    wr(2'd3, 32'd0);
    check("R6 pet clears bark", int'(bark_irq), 0);
    measure(50, nb, nt);
    check("R6 bark restarted", nb, 3);
    check("R6 bite restarted", nt, 8);

    // R7: pet on the expiry edge
    do_reset();
    wr(2'd1, {16'd5, 16'd3});
    wr(2'd0, 32'd1);
    repeat (4) @(posedge clk);
    wr(2'd3, 32'd0);
    check("R7 pet beats bite", int'(bite_rst), 0);
    measure(50, nb, nt);
    check("R7 bite after pet", nt, 5);

    // R4: sticky reset
    wr(2'd3, 32'd0);
    ack();
    repeat (20) @(posedge clk);
    #1;
    check("R4 bite sticky", int'(bite_rst), 1);
    do_reset();
    #1;
    check("R4 rst_n clears bite", int'(bite_rst), 0);

    // R8: rejected limit writes
    wr(2'd1, {16'd5, 16'd3});
    wr(2'd1, {16'd5, 16'd5});
    wr(2'd1, {16'd9, 16'd0});
    wr(2'd1, {16'd2, 16'd4});
    wr(2'd0, 32'd1);
    measure(50, nb, nt);
    check("R8 bark keeps old limit", nb, 3);
    check("R8 bite keeps old limit", nt, 5);
    do_reset();
    wr(2'd1, {16'd9, 16'd4});
    wr(2'd0, 32'd1);
    repeat (2) @(posedge clk);
    wr(2'd1, {16'd6, 16'd6});
    measure(50, nb, nt);
    check("R8 rejected write no restart", nb, 1);

    // R9: disabled
    do_reset();
    wr(2'd1, {16'd4, 16'd2});
    seen = 0;
    for (int n = 0; n < 50; n++) begin
      @(posedge clk); #1;
      if (bark_irq || bite_rst) seen = 1;
    end
    check("R9 disabled silent", seen, 0);
    wr(2'd0, 32'd1);
    wr(2'd0, 32'd0);
    seen = 0;
    for (int n = 0; n < 30; n++) begin
      @(posedge clk); #1;
      if (bark_irq || bite_rst) seen = 1;
    end
    check("R9 disabled mid count", seen, 0);
    wr(2'd0, 32'd1);
    measure(50, nb, nt);
    check("R9 fresh bark on enable", nb, 2);
    check("R9 fresh bite on enable", nt, 4);

    // R10: accepted limit write restarts
    do_reset();
    wr(2'd1, {16'd6, 16'd4});
    wr(2'd0, 32'd1);
    repeat (2) @(posedge clk);
    wr(2'd1, {16'd9, 16'd5});
    measure(50, nb, nt);
    check("R10 bark from limit write", nb, 5);
    check("R10 bite from limit write", nt, 9);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule